// File: doc/BRIEF.md
# Configurable GPIO Port Register Block

This block is one general-purpose I/O port of up to eight pins, controlled by a processor through a small synchronous register bus. Software sets each pin's level, direction and drive style in three writable registers, and reads the live pin levels through a fourth, read-only register. A neighbouring programmable-logic fabric can also force a pin to be an output, and it can take over a pin's output value entirely.

For every pin the block produces a pad output level, a pad output enable and a fast-edge flag. A pin is an output when its software direction bit or the fabric's enable term is set. The value driven comes from the fabric when the fabric claims the pin, and from the software data register otherwise. On pins that support it, the drive-select bit turns the pin into an emulated open-drain output: the pad drives low for a 0 and is released for a 1. On the other pins the same bit only selects a fast slew rate, which is exported as a flag. Pad levels come back through a two-flop synchroniser. A parameter reduces the port to fewer live pins, and the unused pins are tied off.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset, the data, direction and drive registers all read 0, every pad output enable is 0 and every fast flag is 0.
- R2: Register offsets are 0 pin levels (read-only), 1 output data, 2 direction and 3 drive select. A write takes effect at the next rising clock edge. Reads are combinational, and offsets 1 to 3 return the last value written.
- R3: A read at offset 0 returns pad_in after two rising edges of synchronisation, with bit n mapped to pin n. Writes to offset 0 change no register.
- R4: On a push-pull pin, pad_oe is the OR of the direction bit and fab_oe.
- R5: On a push-pull pin that the fabric does not claim (fab_own bit 0), pad_out equals the output data bit.
- R6: When the fab_own bit of a pin is 1, fab_val is used as that pin's value in place of the output data bit. Writes to the output data register still read back, but they do not change that pin.
- R7: Pins whose SLEW_MASK bit is 0 are open-drain capable. When such a pin's drive bit is 1, pad_out is 0 and pad_oe is 1 only when the pin is an output and its value is 0.
- R8: Pins whose SLEW_MASK bit is 1 stay push-pull. Their drive bit appears on pad_fast. pad_fast is 0 on open-drain-capable pins.
- R9: With PINS below 8, bits at positions PINS and above read 0 at every offset, and pad_out, pad_oe and pad_fast are 0 for those pins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| fab_oe | input | 8 | Per-pin output-enable term from the logic fabric |
| fab_own | input | 8 | Per-pin claim of the output value by the fabric |
| fab_val | input | 8 | Fabric output value |
| pad_in | input | 8 | Pin levels seen at the pads |
| pad_out | output | 8 | Pad output level |
| pad_oe | output | 8 | Pad output enable |
| pad_fast | output | 8 | Fast slew flag per pin |

## Verification
Random writes are mixed with random fabric enable, claim and value patterns. These separate the OR of software and fabric direction from a plain software direction, and fabric-owned values from register-driven ones. Drive bits are set on both halves of the port. This shows whether open-drain release on a driven 1 is confined to the capable pins, and whether the fast flag is confined to the others. A full-width instance and a three-pin instance receive identical stimulus, so that any bit leaking past the live-pin limit stands out. Directed cases cover reset, ignored writes at offset 0 and the two-edge input latency.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    parameter int PORT_W = 8;

    typedef logic [PORT_W-1:0] pin_t;

    typedef enum logic [1:0] {
        REG_PIN_IN = 2'd0,
        REG_OUT    = 2'd1,
        REG_DIR    = 2'd2,
        REG_DRIVE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        pin_t dout;
        pin_t dir;
        pin_t drive;
    } cfg_t;

    function automatic pin_t live_mask(input int n);
        pin_t m;
        m = '0;
        for (int i = 0; i < PORT_W; i++) begin
            if (i < n) m[i] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync
    import gpio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  pin_t raw,
    output pin_t synced
);
    typedef struct packed {
        pin_t s1;
        pin_t s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = raw;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign synced = sync_q.s2;
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_pkg::*;
#(
    parameter pin_t LIVE = '1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr,
    input  reg_sel_e sel,
    input  pin_t     wdata,
    output cfg_t     cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr) begin
            case (sel)
                REG_OUT:   cfg_d.dout  = wdata & LIVE;
                REG_DIR:   cfg_d.dir   = wdata & LIVE;
                REG_DRIVE: cfg_d.drive = wdata & LIVE;
                default:   cfg_d       = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive
    import gpio_pkg::*;
#(
    parameter pin_t LIVE      = '1,
    parameter pin_t SLEW_PINS = '0
) (
    input  cfg_t cfg,
    input  pin_t fab_oe,
    input  pin_t fab_own,
    input  pin_t fab_val,
    output pin_t pad_out,
    output pin_t pad_oe,
    output pin_t pad_fast
);
    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
        if (!LIVE[i]) begin : g_dead
            assign pad_out[i]  = 1'b0;
            assign pad_oe[i]   = 1'b0;
            assign pad_fast[i] = 1'b0;
        end else begin : g_live
            logic drive_en;
            logic value;
            assign drive_en = cfg.dir[i] | fab_oe[i];
            assign value    = fab_own[i] ? fab_val[i] : cfg.dout[i];
            if (SLEW_PINS[i]) begin : g_slew
                assign pad_out[i]  = value;
                assign pad_oe[i]   = drive_en;
                assign pad_fast[i] = cfg.drive[i];
            end else begin : g_odcap
                assign pad_out[i]  = cfg.drive[i] ? 1'b0 : value;
                assign pad_oe[i]   = drive_en & ~(cfg.drive[i] & value);
                assign pad_fast[i] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_pkg::*;
#(
    parameter int   PINS      = 8,
    parameter pin_t SLEW_MASK = 8'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic [PORT_W-1:0] fab_oe,
    input  logic [PORT_W-1:0] fab_own,
    input  logic [PORT_W-1:0] fab_val,
    input  logic [PORT_W-1:0] pad_in,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_oe,
    output logic [PORT_W-1:0] pad_fast
);
    localparam pin_t LIVE = live_mask(PINS);

    reg_sel_e sel;
    cfg_t     cfg;
    pin_t     levels;
    pin_t     dout_q, dir_q, drv_q;

    assign sel = reg_sel_e'(bus_addr);

    gpio_cfg_regs #(.LIVE(LIVE)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .sel(sel),
        .wdata(bus_wdata), .cfg(cfg)
    );

    gpio_in_sync u_sync (
        .clk(clk), .rst_n(rst_n), .raw(pad_in), .synced(levels)
    );

    gpio_pin_drive #(.LIVE(LIVE), .SLEW_PINS(SLEW_MASK)) u_drive (
        .cfg(cfg), .fab_oe(fab_oe), .fab_own(fab_own), .fab_val(fab_val),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_fast(pad_fast)
    );

    assign dout_q = cfg.dout;
    assign dir_q  = cfg.dir;
    assign drv_q  = cfg.drive;

    always_comb begin
        case (sel)
            REG_PIN_IN: bus_rdata = levels & LIVE;
            REG_OUT:    bus_rdata = cfg.dout;
            REG_DIR:    bus_rdata = cfg.dir;
            default:    bus_rdata = cfg.drive;
        endcase
    end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_pkg::*;
#(
    parameter int   PINS      = 8,
    parameter pin_t SLEW_MASK = 8'hF0
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] bus_addr,
    input logic       bus_wr,
    input pin_t       bus_rdata,
    input pin_t       fab_oe,
    input pin_t       fab_own,
    input pin_t       fab_val,
    input pin_t       pad_out,
    input pin_t       pad_oe,
    input pin_t       pad_fast,
    input pin_t       dout_q,
    input pin_t       dir_q,
    input pin_t       drv_q
);
    localparam pin_t LIVE = live_mask(PINS);
    pin_t od_en;
    assign od_en = drv_q & ~SLEW_MASK & LIVE;

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dout_q == '0 && dir_q == '0 && drv_q == '0));

    a_r3_pin_reg_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0) |=> $stable({dout_q, dir_q, drv_q}));

    a_r4_dir_or: assert property (@(posedge clk) disable iff (!rst_n)
        (((dir_q | fab_oe) & LIVE & ~od_en & ~pad_oe) == '0));

    a_r6_fabric_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (((pad_out ^ fab_val) & fab_own & LIVE & ~od_en) == '0));

    a_r7_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out & od_en) == '0));

    a_r8_fast_only_slew: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_fast & ~SLEW_MASK) == '0));

    a_r9_dead_pins_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (((pad_oe | pad_out | pad_fast | bus_rdata) & ~LIVE) == '0));
endmodule

bind gpio_port_regs gpio_port_chk #(.PINS(PINS), .SLEW_MASK(SLEW_MASK)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rdata(bus_rdata), .fab_oe(fab_oe), .fab_own(fab_own), .fab_val(fab_val),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_fast(pad_fast),
    .dout_q(dout_q), .dir_q(dir_q), .drv_q(drv_q)
);

// File: tb/tb_gpio_port_regs.sv
module tb_gpio_port_regs;
    localparam logic [7:0] SLEW = 8'hF0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0, fab_oe = '0, fab_own = '0, fab_val = '0, pad_in = '0;
    logic [7:0] rd0, out0, oe0, fast0, rd1, out1, oe1, fast1;

    int checks = 0;
    int bad = 0;
    logic [7:0] m_dout [2];
    logic [7:0] m_dir  [2];
    logic [7:0] m_drv  [2];
    logic [7:0] m_s1, m_s2;
    logic [7:0] live [2];

    always #5 clk = ~clk;

    gpio_port_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(rd0), .fab_oe(fab_oe), .fab_own(fab_own),
        .fab_val(fab_val), .pad_in(pad_in), .pad_out(out0), .pad_oe(oe0), .pad_fast(fast0)
    );

    gpio_port_regs #(.PINS(3)) dut3 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(rd1), .fab_oe(fab_oe), .fab_own(fab_own),
        .fab_val(fab_val), .pad_in(pad_in), .pad_out(out1), .pad_oe(oe1), .pad_fast(fast1)
    );

    function automatic logic [7:0] f_val(int k);
        return (fab_own & fab_val) | (~fab_own & m_dout[k]);
    endfunction
    function automatic logic [7:0] f_od(int k);
        return m_drv[k] & ~SLEW & live[k];
    endfunction
    function automatic logic [7:0] f_out(int k);
        return f_val(k) & ~f_od(k) & live[k];
    endfunction
    function automatic logic [7:0] f_oe(int k);
        return (m_dir[k] | fab_oe) & live[k] & ~(f_od(k) & f_val(k));
    endfunction
    function automatic logic [7:0] f_rd(int k);
        case (bus_addr)
            2'd0:    return m_s2 & live[k];
            2'd1:    return m_dout[k];
            2'd2:    return m_dir[k];
            default: return m_drv[k];
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R2 R3 R9 read wide", rd0, f_rd(0));
        chk("R2 R3 R9 read narrow", rd1, f_rd(1));
        chk("R5 R6 R7 pad_out wide", out0, f_out(0));
        chk("R5 R6 R7 R9 pad_out narrow", out1, f_out(1));
        chk("R4 R7 pad_oe wide", oe0, f_oe(0));
        chk("R4 R7 R9 pad_oe narrow", oe1, f_oe(1));
        chk("R8 pad_fast wide", fast0, m_drv[0] & SLEW);
        chk("R8 R9 pad_fast narrow", fast1, m_drv[1] & SLEW & live[1]);
    endtask

    task automatic step(input logic [1:0] a, input logic w, input logic [7:0] d,
                        input logic [7:0] oe, input logic [7:0] own,
                        input logic [7:0] val, input logic [7:0] pin);
        @(negedge clk);
        bus_addr = a; bus_wr = w; bus_wdata = d;
        fab_oe = oe; fab_own = own; fab_val = val; pad_in = pin;
        @(posedge clk);
        for (int k = 0; k < 2; k++) begin
            if (w) begin
                case (a)
                    2'd1: m_dout[k] = d & live[k];
                    2'd2: m_dir[k]  = d & live[k];
                    2'd3: m_drv[k]  = d & live[k];
                    default: ;
                endcase
            end
        end
        m_s2 = m_s1;
        m_s1 = pin;
        #2;
        compare_all();
    endtask

    initial begin
        #2_000_000;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'h0000_5EED);
        live[0] = 8'hFF; live[1] = 8'h07;
        for (int k = 0; k < 2; k++) begin
            m_dout[k] = '0; m_dir[k] = '0; m_drv[k] = '0;
        end
        m_s1 = '0; m_s2 = '0;

        repeat (3) @(posedge clk);
        for (int a = 1; a < 4; a++) begin
            @(negedge clk);
            bus_addr = 2'(a);
            #1;
            chk("R1 reset reg zero wide", rd0, 8'h00);
            chk("R1 reset reg zero narrow", rd1, 8'h00);
        end
        chk("R1 reset pad_oe", oe0, 8'h00);
        chk("R1 reset pad_fast", fast0, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        step(2'd2, 1'b1, 8'h0F, 8'h00, 8'h00, 8'h00, 8'h00);
        step(2'd1, 1'b1, 8'h55, 8'h30, 8'h00, 8'h00, 8'h00);
        step(2'd0, 1'b1, 8'hFF, 8'h30, 8'h00, 8'h00, 8'hA5);
        step(2'd1, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'hA5);
        step(2'd0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'hA5);
        chk("R3 synced levels after two edges", rd0, 8'hA5);
        step(2'd1, 1'b1, 8'h00, 8'hFF, 8'h0F, 8'h0A, 8'h3C);
        chk("R6 fabric value on claimed pins", out0 & 8'h0F, 8'h0A);
        step(2'd3, 1'b1, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h3C);
        step(2'd1, 1'b1, 8'h0C, 8'h00, 8'h00, 8'h00, 8'h3C);
        chk("R7 open-drain release on high", oe0 & 8'h0F, 8'h03);
        chk("R8 fast flag on slew pins", fast0, 8'hF0);

        for (int n = 0; n < 600; n++) begin
            step(2'($urandom), 1'($urandom), 8'($urandom), 8'($urandom & $urandom),
                 8'($urandom), 8'($urandom), 8'($urandom));
        end

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule